// File: doc/BRIEF.md
# Fixed-Priority Maskable Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor. Peripheral completion pulses set latched request flags. Each flag has its own enable bit, and a master enable driven from the processor status word gates all of them. The block presents the single highest-ranked pending request to the processor as a request line plus a 4-bit slot index. The processor reads the enable and request flags, and writes them, over a plain byte-wide register bus.

Two requests ignore every enable and every flag. The first is the reset slot, which is pending from reset until the first acknowledge. The second is the software break, a level input from the processor. When the processor accepts an interrupt it pulses acknowledge. The winning index is then frozen in a holding register for the vector fetch, and the serviced flag or flags are cleared.

The flag vector is 16 bits, bit 15 down to bit 0. The high byte holds bits 15..8 and the low byte holds bits 7..0. The bits are, in order: ext0, ext1, ext2, ext3, uart0, uart1, sio, tmr0 | tmr1, tmr2, tmr3, tmr4, adc, wdt, wt, bit-timer.

Top module: `intc_fixprio`

## Requirements
- R1: After reset, both enable bytes and both request bytes read 0x00. The held index and held break flag are 0. A reset request is pending, shown as irq_o=1, irq_idx_o=0, irq_brk_o=0, until the first acknowledge.
- R2: The enable high byte sits at 0xEA and the enable low byte at 0xEB, both read/write. The bits use the flag layout given above.
- R3: The request high byte reads at 0xEC and the request low byte at 0xED, and both return the current flags. Writing either byte clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. Any other address reads 0x00.
- R4: A pulse on a source input sets its flag on the next clock edge. Both the receive-done and transmit-done pulses of a UART set that UART's single flag, and the same holds for the serial I/O unit.
- R5: A maskable source is a candidate only when its flag is 1, its enable bit is 1 and ie_master_i is 1. With ie_master_i at 0, no maskable request reaches irq_o.
- R6: The slots rank 0 (reset, highest), then 1 to 4 (ext0 to ext3), 5 (uart0), 6 (uart1), 7 (sio), 8 to 12 (tmr0 to tmr4), 13 (adc), 14 (wdt or wt), 15 (bit-timer, lowest). irq_idx_o gives the lowest-numbered candidate slot.
- R7: Slot 14 is a candidate when wdt is flagged and enabled, or when wt is flagged and enabled. Acknowledging slot 14 clears only the flags that were both set and enabled.
- R8: While brk_i is 1 and no reset request is pending, irq_o=1, irq_brk_o=1 and irq_idx_o=0, whatever the flags, enables and master bit.
- R9: An edge with ack_i=1 and irq_o=1 loads held_idx_o/held_brk_o from irq_idx_o/irq_brk_o. Otherwise the held values do not change.
- R10: An acknowledge of a maskable slot clears its flag(s). If a set pulse and a clear (acknowledge or bus write) hit the same flag at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| ie_master_i | input | 1 | Master enable from the status word |
| brk_i | input | 1 | Software break request (non-maskable) |
| ext_irq_i | input | 4 | External request pulses, bit n = ext n |
| uart_rx_done_i | input | 2 | UART receive-complete pulses, bit n = uart n |
| uart_tx_done_i | input | 2 | UART transmit-complete pulses, bit n = uart n |
| sio_rx_done_i | input | 1 | Serial I/O receive-complete pulse |
| sio_tx_done_i | input | 1 | Serial I/O transmit-complete pulse |
| tmr_done_i | input | 5 | Timer pulses, bit n = timer n |
| adc_done_i | input | 1 | ADC conversion-done pulse |
| wdt_evt_i | input | 1 | Watchdog event pulse |
| wt_evt_i | input | 1 | Watch timer event pulse |
| bit_evt_i | input | 1 | Basic interval timer pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_idx_o | output | 4 | Winning slot index |
| irq_brk_o | output | 1 | Winner is the software break |
| ack_i | input | 1 | Acknowledge from the processor |
| held_idx_o | output | 4 | Slot index captured at acknowledge |
| held_brk_o | output | 1 | Break flag captured at acknowledge |

## Verification
The bench builds the block with its default parameters. These are an 8-bit address and the enable and request bytes at 0xEA to 0xED, so all four registers and several unmapped addresses can be reached from the bus. The directed part walks all fifteen maskable slots in one acknowledge chain. It also covers the shared watchdog slot, break while the master bit is off, and set-versus-clear collisions. The random part mixes sparse pulses, bus writes, master toggles and acknowledges, and compares the results against a bench-side model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int FLAG_W   = 16;
  localparam int NSLOT    = 16;
  localparam int IDX_W    = $clog2(NSLOT);
  localparam int BYTE_W   = 8;
  localparam int LAST_ONE = 13;          // last slot with a single flag bit
  localparam int SLOT_DW  = 14;          // shared watchdog / watch timer slot
  localparam int SLOT_BT  = 15;          // basic interval timer slot
  localparam int BIT_WDT  = 2;
  localparam int BIT_WT   = 1;
  localparam int BIT_BT   = 0;

  typedef struct packed {
    logic             valid;
    logic             brk;
    logic [IDX_W-1:0] idx;
  } win_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  EN_HI_ADDR = 8'hEA,
  parameter logic [7:0]  EN_LO_ADDR = 8'hEB,
  parameter logic [7:0]  RQ_HI_ADDR = 8'hEC,
  parameter logic [7:0]  RQ_LO_ADDR = 8'hED
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_wr_i,
  input  logic [intc_pkg::BYTE_W-1:0] bus_wdata_i,
  input  logic [intc_pkg::FLAG_W-1:0] set_i,
  input  logic [intc_pkg::FLAG_W-1:0] ack_clr_i,
  output logic [intc_pkg::FLAG_W-1:0] en_o,
  output logic [intc_pkg::FLAG_W-1:0] req_o,
  output logic [intc_pkg::BYTE_W-1:0] rdata_o
);
  import intc_pkg::*;
  localparam int NBYTE = FLAG_W / BYTE_W;

  logic [FLAG_W-1:0] en_q, req_q, req_d, wr_keep;
  logic [NBYTE-1:0]  en_ld;

  // one enable byte and one keep-mask byte per byte lane; lane 1 is the high byte
  for (genvar k = 0; k < NBYTE; k++) begin : g_lane
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'((k == NBYTE-1) ? EN_HI_ADDR : EN_LO_ADDR);
    localparam logic [ADDR_W-1:0] RQ_A = ADDR_W'((k == NBYTE-1) ? RQ_HI_ADDR : RQ_LO_ADDR);

    assign en_ld[k] = bus_wr_i && (bus_addr_i == EN_A);
    assign wr_keep[k*BYTE_W +: BYTE_W] =
      (bus_wr_i && (bus_addr_i == RQ_A)) ? bus_wdata_i : {BYTE_W{1'b1}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q[k*BYTE_W +: BYTE_W] <= '0;
      else if (en_ld[k]) en_q[k*BYTE_W +: BYTE_W] <= bus_wdata_i;
    end
  end

  // clears first, then set pulses override them
  always_comb begin
    req_d = (req_q & ~ack_clr_i & wr_keep) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  always_comb begin
    rdata_o = '0;
    if      (bus_addr_i == ADDR_W'(EN_HI_ADDR)) rdata_o = en_q[FLAG_W-1 -: BYTE_W];
    else if (bus_addr_i == ADDR_W'(EN_LO_ADDR)) rdata_o = en_q[BYTE_W-1:0];
    else if (bus_addr_i == ADDR_W'(RQ_HI_ADDR)) rdata_o = req_q[FLAG_W-1 -: BYTE_W];
    else if (bus_addr_i == ADDR_W'(RQ_LO_ADDR)) rdata_o = req_q[BYTE_W-1:0];
  end

  assign en_o  = en_q;
  assign req_o = req_q;

  // R10: a set pulse always leaves its flag set
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));

  // R10: acknowledged flags without a concurrent set are gone next cycle
  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_clr_i & ~set_i)) |=> ((req_q & $past(ack_clr_i & ~set_i)) == '0));

  // R4: flags only rise through a set pulse
  a_r4_rise_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & ~$past(req_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/intc_prio.sv
module intc_prio (
  input  logic [intc_pkg::FLAG_W-1:0] req_i,
  input  logic [intc_pkg::FLAG_W-1:0] en_i,
  input  logic                        master_i,
  input  logic                        rst_pend_i,
  input  logic                        brk_i,
  output intc_pkg::win_t              win_o,
  output logic [intc_pkg::FLAG_W-1:0] clr_o
);
  import intc_pkg::*;

  logic [FLAG_W-1:0] live;
  logic [NSLOT-1:0]  slot_pend;
  logic [IDX_W-1:0]  m_idx;
  logic              m_valid;

  assign live = req_i & en_i & {FLAG_W{master_i}};

  // slots 1..13 each own one flag bit, highest bit first
  assign slot_pend[0] = 1'b0;
  for (genvar s = 1; s <= LAST_ONE; s++) begin : g_slot
    assign slot_pend[s] = live[FLAG_W - s];
  end
  assign slot_pend[SLOT_DW] = live[BIT_WDT] | live[BIT_WT];
  assign slot_pend[SLOT_BT] = live[BIT_BT];

  // lowest-numbered pending slot wins
  always_comb begin
    m_idx = '0;
    for (int s = NSLOT-1; s >= 1; s--) begin
      if (slot_pend[s]) m_idx = IDX_W'(s);
    end
    m_valid = |slot_pend;
  end

  always_comb begin
    win_o = '0;
    clr_o = '0;
    if (rst_pend_i) begin
      win_o.valid = 1'b1;
    end else if (brk_i) begin
      win_o.valid = 1'b1;
      win_o.brk   = 1'b1;
    end else if (m_valid) begin
      win_o.valid = 1'b1;
      win_o.idx   = m_idx;
      if (m_idx == IDX_W'(SLOT_DW)) begin
        clr_o[BIT_WDT] = live[BIT_WDT];
        clr_o[BIT_WT]  = live[BIT_WT];
      end else if (m_idx == IDX_W'(SLOT_BT)) begin
        clr_o[BIT_BT] = 1'b1;
      end else begin
        clr_o[FLAG_W - int'(m_idx)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_ack.sv
module intc_ack (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ack_i,
  input  intc_pkg::win_t             win_i,
  output logic                       fire_o,
  output logic                       rst_pend_o,
  output logic [intc_pkg::IDX_W-1:0] held_idx_o,
  output logic                       held_brk_o
);
  import intc_pkg::*;

  logic             rst_pend_q, rst_pend_d;
  logic [IDX_W-1:0] held_idx_q;
  logic             held_brk_q;

  assign fire_o = ack_i & win_i.valid;

  always_comb begin
    rst_pend_d = rst_pend_q & ~fire_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pend_q <= 1'b1;
    else         rst_pend_q <= rst_pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_idx_q <= '0;
      held_brk_q <= 1'b0;
    end else if (fire_o) begin
      held_idx_q <= win_i.idx;
      held_brk_q <= win_i.brk;
    end
  end

  assign rst_pend_o = rst_pend_q;
  assign held_idx_o = held_idx_q;
  assign held_brk_o = held_brk_q;

  // R9: held values move only on an accepted acknowledge
  a_r9_held_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o |=> ($stable(held_idx_q) && $stable(held_brk_q)));

  // R1: the reset slot is served exactly once and reports index 0
  a_r1_reset_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && rst_pend_q) |=> (!rst_pend_q && held_idx_q == '0 && !held_brk_q));

  a_r1_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_pend_q |=> !rst_pend_q);
endmodule

// File: rtl/intc_fixprio.sv
module intc_fixprio #(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] EN_HI_ADDR = 8'hEA,
  parameter logic [7:0] EN_LO_ADDR = 8'hEB,
  parameter logic [7:0] RQ_HI_ADDR = 8'hEC,
  parameter logic [7:0] RQ_LO_ADDR = 8'hED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              ie_master_i,
  input  logic              brk_i,
  input  logic [3:0]        ext_irq_i,
  input  logic [1:0]        uart_rx_done_i,
  input  logic [1:0]        uart_tx_done_i,
  input  logic              sio_rx_done_i,
  input  logic              sio_tx_done_i,
  input  logic [4:0]        tmr_done_i,
  input  logic              adc_done_i,
  input  logic              wdt_evt_i,
  input  logic              wt_evt_i,
  input  logic              bit_evt_i,
  output logic              irq_o,
  output logic [3:0]        irq_idx_o,
  output logic              irq_brk_o,
  input  logic              ack_i,
  output logic [3:0]        held_idx_o,
  output logic              held_brk_o
);
  import intc_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [FLAG_W-1:0] set_v, en_v, req_v, clr_v, ack_clr;
  win_t              win;
  logic              fire, rst_pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // receive and transmit completions share one flag per serial unit
  assign set_v = {ext_irq_i[0], ext_irq_i[1], ext_irq_i[2], ext_irq_i[3],
                  uart_rx_done_i[0] | uart_tx_done_i[0],
                  uart_rx_done_i[1] | uart_tx_done_i[1],
                  sio_rx_done_i | sio_tx_done_i,
                  tmr_done_i[0], tmr_done_i[1], tmr_done_i[2], tmr_done_i[3], tmr_done_i[4],
                  adc_done_i, wdt_evt_i, wt_evt_i, bit_evt_i};

  assign ack_clr = fire ? clr_v : '0;

  intc_regs #(
    .ADDR_W(ADDR_W), .EN_HI_ADDR(EN_HI_ADDR), .EN_LO_ADDR(EN_LO_ADDR),
    .RQ_HI_ADDR(RQ_HI_ADDR), .RQ_LO_ADDR(RQ_LO_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .set_i(set_v), .ack_clr_i(ack_clr),
    .en_o(en_v), .req_o(req_v), .rdata_o(bus_rdata_o)
  );

  intc_prio u_prio (
    .req_i(req_v), .en_i(en_v), .master_i(ie_master_i),
    .rst_pend_i(rst_pend), .brk_i(brk_i),
    .win_o(win), .clr_o(clr_v)
  );

  intc_ack u_ack (
    .clk_i(clk_i), .rst_ni(rst_n), .ack_i(ack_i), .win_i(win),
    .fire_o(fire), .rst_pend_o(rst_pend),
    .held_idx_o(held_idx_o), .held_brk_o(held_brk_o)
  );

  assign irq_o     = win.valid;
  assign irq_idx_o = win.idx;
  assign irq_brk_o = win.brk;

  // R5: a maskable winner implies the master enable is on
  a_r5_master_gates: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !irq_brk_o && irq_idx_o != 4'd0) |-> ie_master_i);

  // R8: a break always raises the request line
  a_r8_brk_raises: assert property (@(posedge clk_i) disable iff (!rst_n)
    brk_i |-> (irq_o && irq_idx_o == 4'd0));

  // R7/R10: only the flags of one slot are cleared by an acknowledge
  a_r7_clear_scope: assert property (@(posedge clk_i) disable iff (!rst_n)
    fire |-> ($countones(ack_clr) <= 2 && ((ack_clr & ~req_v) == '0)));
endmodule

// File: tb/intc_fixprio_tb_top.sv
module intc_fixprio_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic       bus_wr_i = 1'b0, ie_master_i = 1'b0, brk_i = 1'b0, ack_i = 1'b0;
  logic [3:0] ext_irq_i = '0;
  logic [1:0] uart_rx_done_i = '0, uart_tx_done_i = '0;
  logic       sio_rx_done_i = 1'b0, sio_tx_done_i = 1'b0;
  logic [4:0] tmr_done_i = '0;
  logic       adc_done_i = 1'b0, wdt_evt_i = 1'b0, wt_evt_i = 1'b0, bit_evt_i = 1'b0;
  logic       irq_o, irq_brk_o, held_brk_o;
  logic [3:0] irq_idx_o, held_idx_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  intc_fixprio dut_i (.*);

  int    n_chk = 0, n_err = 0;
  string tag = "R1";
  logic [15:0] m_en = '0, m_req = '0;
  logic        m_rstp = 1'b1, m_hbrk = 1'b0;
  logic [3:0]  m_hidx = '0;

  function automatic logic [15:0] f_setv();
    return {ext_irq_i[0], ext_irq_i[1], ext_irq_i[2], ext_irq_i[3],
            uart_rx_done_i[0] | uart_tx_done_i[0], uart_rx_done_i[1] | uart_tx_done_i[1],
            sio_rx_done_i | sio_tx_done_i, tmr_done_i[0], tmr_done_i[1], tmr_done_i[2],
            tmr_done_i[3], tmr_done_i[4], adc_done_i, wdt_evt_i, wt_evt_i, bit_evt_i};
  endfunction

  // {valid, brk, idx}
  function automatic logic [5:0] f_win();
    logic [15:0] p;
    if (m_rstp) return 6'b10_0000;
    if (brk_i)  return 6'b11_0000;
    if (!ie_master_i) return '0;
    p = m_req & m_en;
    for (int s = 1; s <= 13; s++) if (p[16-s]) return {2'b10, 4'(s)};
    if (p[2] | p[1]) return {2'b10, 4'd14};
    if (p[0]) return {2'b10, 4'd15};
    return '0;
  endfunction

  function automatic logic [15:0] f_clr(logic [3:0] s);
    logic [15:0] p = m_req & m_en;
    if (s == 0)  return '0;
    if (s == 14) return p & 16'h0006;
    if (s == 15) return 16'h0001;
    return 16'(1) << (16 - int'(s));
  endfunction

  function automatic logic [7:0] f_rd();
    case (bus_addr_i)
      8'hEA: return m_en[15:8];
      8'hEB: return m_en[7:0];
      8'hEC: return m_req[15:8];
      8'hED: return m_req[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_pulses();
    ext_irq_i = '0; uart_rx_done_i = '0; uart_tx_done_i = '0;
    sio_rx_done_i = 0; sio_tx_done_i = 0; tmr_done_i = '0;
    adc_done_i = 0; wdt_evt_i = 0; wt_evt_i = 0; bit_evt_i = 0;
    ack_i = 0; bus_wr_i = 0;
  endtask

  // called just after a falling edge with inputs driven
  task automatic do_cycle();
    logic [5:0]  w;
    logic [15:0] keep, nreq, clr;
    #1;
    w = f_win();
    chk("irq", 16'(irq_o), 16'(w[5]));
    chk("idx", 16'(irq_idx_o), 16'(w[3:0]));
    chk("brk", 16'(irq_brk_o), 16'(w[4]));
    chk("held_idx", 16'(held_idx_o), 16'(m_hidx));
    chk("held_brk", 16'(held_brk_o), 16'(m_hbrk));
    chk("rdata", 16'(bus_rdata_o), 16'(f_rd()));
    @(posedge clk_i);
    keep = '1;
    if (bus_wr_i && bus_addr_i == 8'hEC) keep[15:8] = bus_wdata_i;
    if (bus_wr_i && bus_addr_i == 8'hED) keep[7:0]  = bus_wdata_i;
    clr  = (ack_i && w[5]) ? f_clr(w[3:0]) : '0;
    nreq = (m_req & ~clr & keep) | f_setv();
    if (bus_wr_i && bus_addr_i == 8'hEA) m_en[15:8] = bus_wdata_i;
    if (bus_wr_i && bus_addr_i == 8'hEB) m_en[7:0]  = bus_wdata_i;
    if (ack_i && w[5]) begin
      m_hidx = w[3:0]; m_hbrk = w[4]; m_rstp = 1'b0;
    end
    m_req = nreq;
    @(negedge clk_i);
    clear_pulses();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1; do_cycle();
  endtask

  task automatic rd(logic [7:0] a);
    bus_addr_i = a; do_cycle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    tag = "R1"; // reset values, reset slot pending then served once
    rd(8'hEA); rd(8'hEB); rd(8'hEC); rd(8'hED);
    ack_i = 1; do_cycle(); rd(8'hEA);

    tag = "R2";
    wr(8'hEA, 8'hA5); rd(8'hEA); wr(8'hEB, 8'h3C); rd(8'hEB); rd(8'hEA);

    tag = "R4"; // rx or tx of one unit sets the same flag
    uart_rx_done_i = 2'b01; do_cycle(); rd(8'hEC);
    uart_tx_done_i = 2'b10; sio_tx_done_i = 1; do_cycle(); rd(8'hEC);
    sio_rx_done_i = 1; tmr_done_i = 5'b00010; do_cycle(); rd(8'hED);

    tag = "R3"; // write-0 clears, write-1 keeps, unmapped reads zero
    wr(8'hEC, 8'hF7); rd(8'hEC); wr(8'hED, 8'h00); rd(8'hED);
    rd(8'h10); rd(8'hFF); rd(8'hE9); rd(8'hEE);

    tag = "R5"; // master off blocks every maskable source
    wr(8'hEA, 8'hFF); wr(8'hEB, 8'hFF);
    ext_irq_i = '1; uart_rx_done_i = '1; sio_rx_done_i = 1; tmr_done_i = '1;
    adc_done_i = 1; wdt_evt_i = 1; wt_evt_i = 1; bit_evt_i = 1;
    do_cycle(); rd(8'hEC); ack_i = 1; do_cycle(); rd(8'hED);

    tag = "R6"; // full chain: slots 1..15 in order
    ie_master_i = 1;
    for (int k = 0; k < 17; k++) begin ack_i = 1; do_cycle(); end
    rd(8'hEC); rd(8'hED);

    tag = "R7"; // only watch timer enabled in the shared slot
    wr(8'hEB, 8'h02); wdt_evt_i = 1; wt_evt_i = 1; do_cycle();
    ack_i = 1; rd(8'hED); rd(8'hED);
    wr(8'hEB, 8'h04); ack_i = 1; rd(8'hED); rd(8'hED);

    tag = "R8"; // break with master off and no flags
    ie_master_i = 0; brk_i = 1; do_cycle(); ack_i = 1; do_cycle(); do_cycle();
    brk_i = 0; do_cycle();

    tag = "R10"; // set beats ack clear and bus clear
    ie_master_i = 1; ext_irq_i = 4'b0001; do_cycle();
    ext_irq_i = 4'b0001; ack_i = 1; rd(8'hEC); rd(8'hEC);
    ext_irq_i = 4'b0001; wr(8'hEC, 8'h00); rd(8'hEC);
    ack_i = 1; do_cycle(); rd(8'hEC);

    tag = "R9 R5 R6 R7"; // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pick;
      ext_irq_i      = 4'(($urandom % 12 == 0) ? $urandom : 0);
      uart_rx_done_i = 2'(($urandom % 14 == 0) ? $urandom : 0);
      uart_tx_done_i = 2'(($urandom % 14 == 0) ? $urandom : 0);
      sio_rx_done_i  = ($urandom % 25 == 0);
      sio_tx_done_i  = ($urandom % 25 == 0);
      tmr_done_i     = 5'(($urandom % 10 == 0) ? $urandom : 0);
      adc_done_i     = ($urandom % 20 == 0);
      wdt_evt_i      = ($urandom % 20 == 0);
      wt_evt_i       = ($urandom % 20 == 0);
      bit_evt_i      = ($urandom % 20 == 0);
      ie_master_i    = ($urandom % 5 != 0);
      brk_i          = ($urandom % 30 == 0);
      ack_i          = ($urandom % 3 == 0);
      pick = 8'($urandom % 6);
      bus_addr_i = (pick < 4) ? 8'hEA + pick : 8'($urandom);
      bus_wr_i = ($urandom % 6 == 0);
      bus_wdata_i = 8'($urandom);
      do_cycle();
    end
    finish_run();
  end
endmodule